// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources and turns them into one request line for a host processor. Each source has a pending bit that follows its request line, an enable bit in a mask register and an in-service bit. A source can be presented to the host when its request is pending, it is unmasked, it is not already in service and it is not the reserved error source. The controller resolves one winner among those sources. Four neighbouring sources form a serial-channel group, and their relative order is set in software. A configuration field can also pick one source that beats every other.

The host fetches a vector in two steps. It first writes a 1 to the acknowledge bit of the vector register. It then reads that register and takes the 5-bit vector from bits 15:11. The acknowledge latches the current winner and marks that source in service. If nothing is eligible at that moment, the latched value is the error vector. This happens when a mask write races with a request that was just raised, and the host only has to acknowledge it. End-of-interrupt is a write of ones to the in-service register. The configuration register also gives the host-level number of the combined output.

Register map (word address on `bus_addr`): 0 configuration, 1 mask, 2 pending (read only), 3 in-service (write-one-to-clear), 4 vector. Configuration fields: bits 7:0 serial-group order (four 2-bit slots), bits 12:8 override source, bits 15:13 half the host level, bit 23 global enable.

Top module: `vic_top`

## Requirements
- R1: After reset, irq_out is 0, the mask, in-service and vector registers read 0, and the configuration register reads 0x0000001B.
- R2: Mask bit v enables source v when set. A pending source whose mask bit is clear never raises irq_out and is never returned as a vector.
- R3: Pending bit v follows src_req[v] one clock later and clears when the request is withdrawn. The pending register reads at word 2.
- R4: irq_out is 1 only while configuration bit 23 is set and at least one source is eligible (pending, unmasked, not in service).
- R5: Outside the override and the serial group, the eligible source with the highest vector number wins.
- R6: Sources 26 to 29 form the serial group and occupy rank positions 26 to 29. Configuration slot k (bits 2k+1:2k) names the channel (vector 26 plus slot value) placed at rank position 29-k. The slots must form a permutation, and the reset value 0x1B gives the natural order.
- R7: When the source named by configuration bits 12:8 is eligible, it wins over every other source.
- R8: A write to word 4 with bit 0 set latches the winner, which is then read back at bits 15:11 of word 4 with all other bits 0. A write to word 4 with bit 0 clear changes neither the vector nor the in-service register.
- R9: An acknowledge that returns a source sets that source's in-service bit, and the source is not presented again until the bit is cleared. Writing 1 to bit v of word 3 clears in-service bit v. Bits written as 0 are unaffected.
- R10: An acknowledge with no eligible source returns error vector 0 and leaves the in-service register unchanged.
- R11: host_level equals twice the value of configuration bits 15:13.
- R12: The request and the mask bit of source 0 (the error vector) are ignored. Pending bit 0 and mask bit 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level request per source |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read strobe |
| irq_out | output | 1 | Combined request to the host |
| host_level | output | 4 | Host interrupt level of irq_out |

## Verification
A change on src_req reaches the pending register at the next rising edge. From there irq_out changes in the same cycle, because it is decoded from register state only. A register write takes effect at the edge that samples the strobe. Read data appears one edge after the read strobe. The bench therefore drives on falling edges, leaves at least two edges between a request change and the irq_out check, and samples read data at the falling edge that follows the sampling edge. Each vector is checked by an acknowledge write followed by a separate read, which is the same order the host uses.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CFG   = 3'd0,
    RA_MASK  = 3'd1,
    RA_PEND  = 3'd2,
    RA_INSRV = 3'd3,
    RA_VEC   = 3'd4
  } reg_addr_e;

  localparam int CFG_ORD_LSB = 0;
  localparam int CFG_HP_LSB  = 8;
  localparam int CFG_LVL_LSB = 13;
  localparam int CFG_LVL_W   = 3;
  localparam int CFG_EN_BIT  = 23;
  localparam logic [31:0] CFG_RST = 32'h0000_001B;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int N       = 32,
  parameter int ERR_VEC = 0,
  parameter int VW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_req,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          clr_we,
  input  logic [N-1:0]  clr_data,
  input  logic          set_we,
  input  logic [VW-1:0] set_idx,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  insrv_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (i == ERR_VEC) begin : g_rsv
      assign pend_q[i]  = 1'b0;
      assign mask_q[i]  = 1'b0;
      assign insrv_q[i] = 1'b0;
    end else begin : g_live
      logic pend_d, mask_d, insrv_d;
      logic pend_r, mask_r, insrv_r;

      always_comb begin
        pend_d  = src_req[i];
        mask_d  = mask_we ? mask_wdata[i] : mask_r;
        insrv_d = insrv_r;
        if (clr_we && clr_data[i]) insrv_d = 1'b0;
        if (set_we && (set_idx == VW'(i))) insrv_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_r  <= 1'b0;
          mask_r  <= 1'b0;
          insrv_r <= 1'b0;
        end else begin
          pend_r  <= pend_d;
          mask_r  <= mask_d;
          insrv_r <= insrv_d;
        end
      end

      assign pend_q[i]  = pend_r;
      assign mask_q[i]  = mask_r;
      assign insrv_q[i] = insrv_r;
    end
  end
endmodule

// File: rtl/vic_prio_sel.sv
module vic_prio_sel #(
  parameter int N        = 32,
  parameter int SER_BASE = 26,
  parameter int VW       = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [VW-1:0] hp_sel,
  input  logic [7:0]    grp_ord,
  output logic          any,
  output logic [VW-1:0] vec
);
  localparam int GRP = 4;

  logic [N-1:0]  rank;
  logic [VW-1:0] best;

  always_comb begin
    rank = elig;
    for (int k = 0; k < GRP; k++) begin
      rank[SER_BASE+GRP-1-k] = elig[SER_BASE + int'(grp_ord[2*k +: 2])];
    end
    best = '0;
    for (int r = 0; r < N; r++) begin
      if (rank[r]) best = VW'(r);
    end
    vec = best;
    for (int k = 0; k < GRP; k++) begin
      if (best == VW'(SER_BASE+GRP-1-k)) vec = VW'(SER_BASE) + VW'(grp_ord[2*k +: 2]);
    end
    if (elig[hp_sel]) vec = hp_sel;
    any = (|rank) | elig[hp_sel];
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int N        = 32,
  parameter int ERR_VEC  = 0,
  parameter int SER_BASE = 26,
  localparam int VW      = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic [3:0]        host_level
);
  localparam int VEC_LSB = 16 - VW;

  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [31:0]   cfg_q, cfg_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [31:0]   rdata_q, rdata_d;
  logic [N-1:0]  pend_q, mask_q, insrv_q, elig;
  logic          sel_any;
  logic [VW-1:0] sel_vec;
  logic          cfg_we, mask_we, clr_we, ack_wr, set_we;
  logic          cfg_en;

  assign cfg_we  = bus_wr && (bus_addr == RA_CFG);
  assign mask_we = bus_wr && (bus_addr == RA_MASK);
  assign clr_we  = bus_wr && (bus_addr == RA_INSRV);
  assign ack_wr  = bus_wr && (bus_addr == RA_VEC) && bus_wdata[0];
  assign set_we  = ack_wr && sel_any;
  assign cfg_en  = cfg_q[CFG_EN_BIT];

  vic_src_bank #(.N(N), .ERR_VEC(ERR_VEC), .VW(VW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_s),
    .src_req    (src_req),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata[N-1:0]),
    .clr_we     (clr_we),
    .clr_data   (bus_wdata[N-1:0]),
    .set_we     (set_we),
    .set_idx    (sel_vec),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .insrv_q    (insrv_q)
  );

  assign elig = pend_q & mask_q & ~insrv_q;

  vic_prio_sel #(.N(N), .SER_BASE(SER_BASE), .VW(VW)) u_sel (
    .elig    (elig),
    .hp_sel  (cfg_q[CFG_HP_LSB +: VW]),
    .grp_ord (cfg_q[CFG_ORD_LSB +: 8]),
    .any     (sel_any),
    .vec     (sel_vec)
  );

  always_comb begin
    cfg_d = cfg_we ? bus_wdata : cfg_q;
    vec_d = vec_q;
    if (ack_wr) vec_d = sel_any ? sel_vec : VW'(ERR_VEC);
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        RA_CFG:   rdata_d = cfg_q;
        RA_MASK:  rdata_d = 32'(mask_q);
        RA_PEND:  rdata_d = 32'(pend_q);
        RA_INSRV: rdata_d = 32'(insrv_q);
        RA_VEC:   rdata_d = 32'(vec_q) << VEC_LSB;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_q   <= CFG_RST;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      vec_q   <= vec_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign irq_out    = cfg_en && (|elig);
  assign host_level = {cfg_q[CFG_LVL_LSB +: CFG_LVL_W], 1'b0};
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
  parameter int N       = 32,
  parameter int ERR_VEC = 0,
  parameter int VW      = 5
) (
  input logic          clk,
  input logic          rst_s,
  input logic [N-1:0]  src_req,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  insrv_q,
  input logic          ack_wr,
  input logic          sel_any,
  input logic [VW-1:0] vec_q,
  input logic          cfg_en,
  input logic          irq_out,
  input logic [3:0]    host_level
);
  localparam logic [N-1:0] KEEP = ~(N'(1) << ERR_VEC);

  assert_pend_follows_R3: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (pend_q == ($past(src_req) & KEEP)));

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg_en |-> !irq_out);

  assert_irq_needs_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_s)
    irq_out |-> |(pend_q & mask_q & ~insrv_q));

  assert_ack_marks_insrv_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_wr && sel_any) |=> insrv_q[vec_q]);

  assert_err_vector_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_wr && !sel_any) |=> ((vec_q == VW'(ERR_VEC)) && $stable(insrv_q)));

  always_comb begin
    if (rst_s) begin
      assert_level_even_R11: assert (host_level[0] == 1'b0);
    end
  end
endmodule

bind vic_top vic_top_chk #(.N(N), .ERR_VEC(ERR_VEC), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .src_req    (src_req),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .insrv_q    (insrv_q),
  .ack_wr     (ack_wr),
  .sel_any    (sel_any),
  .vec_q      (vec_q),
  .cfg_en     (cfg_en),
  .irq_out    (irq_out),
  .host_level (host_level)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [3:0]  host_level;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  vic_top u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .host_level(host_level)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] msk;
    logic [31:0] cfg;
    logic [4:0]  vec;
    logic [3:0]  rq;
  } row_t;

  localparam int ROWS = 10;
  localparam row_t TBL [ROWS] = '{
    '{32'h0000_0012, 32'hFFFF_FFFF, 32'h0080_001B, 5'd4,  4'd5},  // R5 highest number
    '{32'h8000_0002, 32'h7FFF_FFFF, 32'h0080_001B, 5'd1,  4'd2},  // R2 masked 31
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0080_001B, 5'd0,  4'd10}, // R10 nothing pending
    '{32'h3C00_0000, 32'hFFFF_FFFF, 32'h0080_001B, 5'd29, 4'd6},  // R6 natural order
    '{32'h3C00_0000, 32'hFFFF_FFFF, 32'h0080_00E4, 5'd26, 4'd6},  // R6 reversed
    '{32'h2400_0000, 32'hFFFF_FFFF, 32'h0080_001E, 5'd29, 4'd6},  // R6 channel 3 at rank 28
    '{32'h0010_0008, 32'hFFFF_FFFF, 32'h0080_031B, 5'd3,  4'd7},  // R7 override wins
    '{32'h0010_0008, 32'hFFFF_FFFF, 32'h0080_051B, 5'd20, 4'd7},  // R7 override idle
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0080_001B, 5'd0,  4'd12}, // R12 source 0 ignored
    '{32'hC000_0000, 32'hFFFF_FFFF, 32'h0080_001B, 5'd31, 4'd5}   // R5 top source
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    bus_read(3'd0, d); chk("R1 cfg", d, 32'h0000_001B);
    bus_read(3'd1, d); chk("R1 mask", d, 32'h0);
    bus_read(3'd3, d); chk("R1 insrv", d, 32'h0);
    bus_read(3'd4, d); chk("R1 vec", d, 32'h0);

    // table walk
    for (int i = 0; i < ROWS; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].rq, i);
      src_req = TBL[i].req;
      bus_write(3'd1, TBL[i].msk);
      bus_write(3'd0, TBL[i].cfg);
      idle(2);
      chk({tag, " irq"}, 32'(irq_out), (TBL[i].vec != 5'd0) ? 32'h1 : 32'h0);
      bus_write(3'd4, 32'h1);
      bus_read(3'd4, d);
      chk({tag, " vec"}, d, 32'(TBL[i].vec) << 11);
      bus_write(3'd3, 32'hFFFF_FFFF);
    end

    // R12 mask bit 0 and pending bit 0 read 0
    src_req = 32'h0000_0001;
    bus_write(3'd1, 32'hFFFF_FFFF);
    idle(2);
    bus_read(3'd1, d); chk("R12 mask bit0", d, 32'hFFFF_FFFE);
    bus_read(3'd2, d); chk("R12 pend bit0", d, 32'h0);

    // R4 enable gating
    bus_write(3'd0, 32'h0000_001B);
    src_req = 32'h0000_0010;
    idle(2);
    chk("R4 disabled", 32'(irq_out), 32'h0);
    bus_write(3'd0, 32'h0080_001B);
    idle(1);
    chk("R4 enabled", 32'(irq_out), 32'h1);

    // R3 pending follows level
    bus_read(3'd2, d); chk("R3 pend set", d, 32'h0000_0010);
    src_req = 32'h0;
    idle(2);
    bus_read(3'd2, d); chk("R3 pend clear", d, 32'h0);
    chk("R3 irq drop", 32'(irq_out), 32'h0);

    // R2 masked pending source
    src_req = 32'h0000_0100;
    bus_write(3'd1, 32'hFFFF_FEFF);
    idle(2);
    chk("R2 masked irq", 32'(irq_out), 32'h0);
    bus_read(3'd2, d); chk("R2 still pending", d, 32'h0000_0100);

    // R9 in-service tracking and write-one-to-clear
    src_req = 32'h0000_0400;
    bus_write(3'd1, 32'hFFFF_FFFF);
    idle(2);
    bus_write(3'd4, 32'h1);
    bus_read(3'd4, d); chk("R9 vec 10", d, 32'd10 << 11);
    chk("R9 not presented", 32'(irq_out), 32'h0);
    bus_read(3'd3, d); chk("R9 insrv set", d, 32'h0000_0400);
    bus_write(3'd3, 32'hFFFF_FBFF);
    bus_read(3'd3, d); chk("R9 zeros ignored", d, 32'h0000_0400);

    // R8 write without acknowledge bit
    src_req = 32'h0000_0C00;
    idle(2);
    bus_write(3'd4, 32'hFFFF_FFFE);
    bus_read(3'd4, d); chk("R8 vec kept", d, 32'd10 << 11);
    bus_read(3'd3, d); chk("R8 insrv kept", d, 32'h0000_0400);

    // R10 error acknowledge while source 11 is masked
    bus_write(3'd1, 32'hFFFF_F7FF);
    bus_write(3'd4, 32'h1);
    bus_read(3'd4, d); chk("R10 error vec", d, 32'h0);
    bus_read(3'd3, d); chk("R10 insrv kept", d, 32'h0000_0400);

    bus_write(3'd3, 32'h0000_0400);
    bus_read(3'd3, d); chk("R9 insrv cleared", d, 32'h0);
    chk("R9 presented again", 32'(irq_out), 32'h1);

    // R11 host level
    bus_write(3'd0, 32'h0080_A01B);
    chk("R11 level", 32'(host_level), 32'd10);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule